// File: doc/BRIEF.md
# Cubic Fractional-Delay Interpolator

This block produces one output sample at an arbitrary fractional position inside a stream of input samples that has already been raised to eight times its original rate. It is the arithmetic core of a fractional sample rate converter. A separate timing source decides when an output is due and supplies the fractional offset `t`. The upsampling filter, the crossing between clock domains and the rate tracking that produces `t` all sit outside this block.

The block holds the four most recent input samples. Counting from oldest to newest, they are the support points at relative positions -1, 0, 1 and 2. On each request it fits the unique cubic `P(t) = c3·t³ + c2·t² + c1·t + c0` through those four points, using closed-form coefficients. The division by six is done as a multiply by a rounded reciprocal. The block then evaluates the cubic in nested (Horner) form at `t/2^T_W`. The pipeline has four register stages. The result is rounded to nearest and saturated to the output width.

Top module: `cubic_frac_interp`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low. After reset, no sample counts as loaded.
- R2: A request on `req_valid` is ignored until four input samples have been loaded since reset. An ignored request never produces an `out_valid` pulse.
- R3: Every cycle with `in_valid` high shifts `in_sample` into the window. The window always holds the four most recent samples, oldest at position -1 and newest at position 2.
- R4: An accepted request yields exactly one `out_valid` pulse. The pulse appears after the fourth rising edge, counting the edge that accepts the request as the first. Requests on consecutive cycles give pulses on consecutive cycles.
- R5: When `req_frac` is 0, `out_sample` equals the sample at position 0 exactly.
- R6: `out_sample` equals the cubic through the four window samples, evaluated at `req_frac/65536`, to within one LSB. `req_frac` is an unsigned fraction, and `in_sample` and `out_sample` are 16-bit two's complement.
- R7: A result above 32767 gives 32767, and a result below -32768 gives -32768.
- R8: If a request and a new sample arrive in the same cycle, the request uses the window as it stood before that sample was shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | IN_W | Upsampled input sample, signed |
| req_valid | input | 1 | Request for one interpolated output |
| req_frac | input | T_W | Fractional position t, unsigned, in units of 2^-T_W |
| out_valid | output | 1 | Qualifies `out_sample` for one cycle |
| out_sample | output | IN_W | Interpolated sample, rounded and saturated |

## Verification
The properties take for granted that `req_valid` is only asserted while the caller does not care about requests dropped before the window is full. They count loaded samples themselves, so that rule is checked rather than trusted. They also assume that `in_sample` and `req_frac` are stable whenever their qualifiers are sampled. The stimulus drives every input on the falling edge, and it fills the window with four fresh samples before each table vector. Only the back-to-back and same-cycle tests deliberately overlap requests with loads.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

   // Number of support points of the cubic: positions -1, 0, 1, 2
   localparam int unsigned CFI_TAPS = 4;

   // round(2^frac / div) computed at elaboration
   function automatic longint unsigned cfi_recip(input int unsigned frac,
                                                 input int unsigned div);
      longint unsigned num;
      num = (64'd1 << (frac + 1)) / longint'(div);
      return (num + 64'd1) >> 1;
   endfunction

endpackage

// File: rtl/cfi_window.sv
module cfi_window
   import cfi_pkg::*;
#(
   parameter int unsigned IN_W = 16,
   parameter int unsigned TAPS = CFI_TAPS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       shift_en,
   input  logic [IN_W-1:0]            shift_in,
   output logic [TAPS-1:0][IN_W-1:0]  taps,
   output logic                       primed
);
   localparam int unsigned CNT_W = $clog2(TAPS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(TAPS);

   logic [CNT_W-1:0] fill_q;

   // taps[0] is the oldest sample, taps[TAPS-1] the newest
   genvar gi;
   generate
      for (gi = 0; gi < TAPS; gi++) begin : g_tap
         if (gi == TAPS - 1) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        taps[gi] <= '0;
               else if (shift_en) taps[gi] <= shift_in;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        taps[gi] <= '0;
               else if (shift_en) taps[gi] <= taps[gi+1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         fill_q <= '0;
      else if (shift_en && fill_q != FULL) fill_q <= fill_q + 1'b1;
   end

   assign primed = (fill_q == FULL);
endmodule

// File: rtl/cfi_coef.sv
module cfi_coef
   import cfi_pkg::*;
#(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned T_W    = 16,
   parameter int unsigned FRAC   = 16,
   parameter int unsigned COEF_W = IN_W + FRAC + 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic [CFI_TAPS-1:0][IN_W-1:0]    taps,
   input  logic [T_W-1:0]                   frac_in,
   output logic                             vld_o,
   output logic [CFI_TAPS-1:0][COEF_W-1:0]  coef_o,
   output logic [T_W-1:0]                   frac_o
);
   localparam int unsigned NUM_W = IN_W + 4;
   localparam longint unsigned RECIP_U = cfi_recip(FRAC, 6);
   localparam logic signed [COEF_W-1:0] RECIP6 = COEF_W'(RECIP_U);

   logic signed [NUM_W-1:0]  pm1, p0, p1, p2;
   logic signed [NUM_W-1:0]  curv2, diff, num;
   logic signed [COEF_W-1:0] k0, k1, k2, k3;

   assign pm1 = NUM_W'($signed(taps[0]));
   assign p0  = NUM_W'($signed(taps[1]));
   assign p1  = NUM_W'($signed(taps[2]));
   assign p2  = NUM_W'($signed(taps[3]));

   // curv2 = 2*c2, diff = 2*(c1 + c3), num = 6*c3
   assign curv2 = pm1 + p1 - (p0 <<< 1);
   assign diff  = p1 - pm1;
   assign num   = p2 - p0 - (curv2 <<< 1) - diff;

   // Coefficients in signed fixed point with FRAC fraction bits
   assign k3 = COEF_W'(num) * RECIP6;
   assign k2 = COEF_W'(curv2) <<< (FRAC - 1);
   assign k1 = (COEF_W'(diff) <<< (FRAC - 1)) - k3;
   assign k0 = COEF_W'(p0) <<< FRAC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         coef_o <= '0;
         frac_o <= '0;
      end else begin
         vld_o <= en;
         if (en) begin
            coef_o[0] <= k0;
            coef_o[1] <= k1;
            coef_o[2] <= k2;
            coef_o[3] <= k3;
            frac_o    <= frac_in;
         end
      end
   end
endmodule

// File: rtl/cfi_horner_step.sv
module cfi_horner_step
   import cfi_pkg::*;
#(
   parameter int unsigned T_W    = 16,
   parameter int unsigned COEF_W = 37,
   parameter int unsigned ACC_W  = COEF_W + 2,
   parameter int unsigned STEP   = 0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             vld_i,
   input  logic signed [ACC_W-1:0]          acc_i,
   input  logic [CFI_TAPS-1:0][COEF_W-1:0]  coef_i,
   input  logic [T_W-1:0]                   frac_i,
   output logic                             vld_o,
   output logic signed [ACC_W-1:0]          acc_o,
   output logic [CFI_TAPS-1:0][COEF_W-1:0]  coef_o,
   output logic [T_W-1:0]                   frac_o
);
   localparam int unsigned PROD_W = ACC_W + T_W + 1;
   localparam int unsigned SEL    = CFI_TAPS - 2 - STEP;

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] scaled;
   logic signed [ACC_W-1:0]  addend;
   logic signed [ACC_W-1:0]  acc_n;

   assign prod   = PROD_W'(acc_i) * PROD_W'($signed({1'b0, frac_i}));
   assign scaled = prod >>> T_W;
   assign addend = ACC_W'($signed(coef_i[SEL]));
   assign acc_n  = ACC_W'(scaled) + addend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         acc_o  <= '0;
         coef_o <= '0;
         frac_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            acc_o  <= acc_n;
            coef_o <= coef_i;
            frac_o <= frac_i;
         end
      end
   end
endmodule

// File: rtl/cfi_out_stage.sv
module cfi_out_stage #(
   parameter int unsigned IN_W      = 16,
   parameter int unsigned FRAC      = 16,
   parameter int unsigned ACC_W     = 39,
   parameter bit          ROUND_NEAR = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic [IN_W-1:0]         sample_o
);
   localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC - 1);
   localparam logic signed [ACC_W-1:0] MAXV   = ACC_W'((1 << (IN_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] MINV   = -(ACC_W'(1) <<< (IN_W - 1));

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] whole;

   generate
      if (ROUND_NEAR) begin : g_near
         assign biased = acc_i + HALF;
      end else begin : g_trunc
         assign biased = acc_i;
      end
   endgenerate

   assign whole = biased >>> FRAC;

   always_comb begin
      if (whole > MAXV)      sample_o = MAXV[IN_W-1:0];
      else if (whole < MINV) sample_o = MINV[IN_W-1:0];
      else                   sample_o = whole[IN_W-1:0];
   end
endmodule

// File: rtl/cubic_frac_interp.sv
module cubic_frac_interp
   import cfi_pkg::*;
#(
   parameter int unsigned IN_W       = 16,
   parameter int unsigned T_W        = 16,
   parameter int unsigned FRAC       = 16,
   parameter bit          ROUND_NEAR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_sample,
   input  logic            req_valid,
   input  logic [T_W-1:0]  req_frac,
   output logic            out_valid,
   output logic [IN_W-1:0] out_sample
);
   localparam int unsigned COEF_W = IN_W + FRAC + 5;
   localparam int unsigned ACC_W  = COEF_W + 2;
   localparam int unsigned NSTEP  = CFI_TAPS - 1;

   generate
      if (FRAC < 3)  begin : g_bad_frac $error("FRAC needs at least 3 guard bits"); end
      if (IN_W < 4)  begin : g_bad_inw  $error("IN_W must be at least 4"); end
      if (T_W < 2)   begin : g_bad_tw   $error("T_W must be at least 2"); end
      if (COEF_W > 60) begin : g_bad_cw $error("coefficient width too large"); end
   endgenerate

   logic [CFI_TAPS-1:0][IN_W-1:0] taps;
   logic                          primed;
   logic                          accept;

   cfi_window #(.IN_W(IN_W), .TAPS(CFI_TAPS)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .shift_in (in_sample),
      .taps     (taps),
      .primed   (primed)
   );

   assign accept = req_valid && primed;

   logic                            st_vld  [NSTEP+1];
   logic signed [ACC_W-1:0]         st_acc  [NSTEP+1];
   logic [CFI_TAPS-1:0][COEF_W-1:0] st_coef [NSTEP+1];
   logic [T_W-1:0]                  st_frac [NSTEP+1];

   cfi_coef #(.IN_W(IN_W), .T_W(T_W), .FRAC(FRAC), .COEF_W(COEF_W)) u_coef (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (accept),
      .taps    (taps),
      .frac_in (req_frac),
      .vld_o   (st_vld[0]),
      .coef_o  (st_coef[0]),
      .frac_o  (st_frac[0])
   );

   // Horner seed: leading coefficient
   assign st_acc[0] = ACC_W'($signed(st_coef[0][CFI_TAPS-1]));

   genvar gs;
   generate
      for (gs = 0; gs < NSTEP; gs++) begin : g_step
         cfi_horner_step #(
            .T_W(T_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .STEP(gs)
         ) u_step (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (st_vld[gs]),
            .acc_i  (st_acc[gs]),
            .coef_i (st_coef[gs]),
            .frac_i (st_frac[gs]),
            .vld_o  (st_vld[gs+1]),
            .acc_o  (st_acc[gs+1]),
            .coef_o (st_coef[gs+1]),
            .frac_o (st_frac[gs+1])
         );
      end
   endgenerate

   cfi_out_stage #(
      .IN_W(IN_W), .FRAC(FRAC), .ACC_W(ACC_W), .ROUND_NEAR(ROUND_NEAR)
   ) u_out (
      .acc_i    (st_acc[NSTEP]),
      .sample_o (out_sample)
   );

   assign out_valid = st_vld[NSTEP];
endmodule

// File: rtl/cfi_checker.sv
module cfi_checker #(
   parameter int unsigned IN_W = 16,
   parameter int unsigned T_W  = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [IN_W-1:0] in_sample,
   input logic            req_valid,
   input logic [T_W-1:0]  req_frac,
   input logic            out_valid,
   input logic [IN_W-1:0] out_sample
);
   logic [2:0]      seen_q;
   logic [IN_W-1:0] h0, h1, h2, h3;   // h3 newest, h1 is position 0
   logic            took;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         h0 <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
      end else if (in_valid) begin
         if (seen_q != 3'd4) seen_q <= seen_q + 3'd1;
         h0 <= h1; h1 <= h2; h2 <= h3; h3 <= in_sample;
      end
   end

   assign took = req_valid && (seen_q == 3'd4);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_idle_r1: assert (!out_valid);
      end
   end

   p_early_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seen_q != 3'd4) |-> ##4 !out_valid);

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      took |-> ##4 out_valid);

   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(took, 4));

   p_zero_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (took && req_frac == '0) |-> ##4 (out_sample == $past(h1, 4)));
endmodule

bind cubic_frac_interp cfi_checker #(.IN_W(IN_W), .T_W(T_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sample  (in_sample),
   .req_valid  (req_valid),
   .req_frac   (req_frac),
   .out_valid  (out_valid),
   .out_sample (out_sample)
);

// File: tb/cubic_frac_interp_tb.sv
module cubic_frac_interp_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_sample = '0;
   logic        req_valid = 1'b0;
   logic [15:0] req_frac = '0;
   logic        out_valid;
   logic [15:0] out_sample;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cubic_frac_interp u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sample(in_sample),
      .req_valid(req_valid), .req_frac(req_frac),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   // Vectors: oldest(-1), pos 0, pos 1, newest(2), frac
   localparam int NV = 10;
   localparam int VEC [NV][5] = '{
      '{     0,      0,      0,      0, 32768},
      '{   100,    200,    300,    400, 16384},
      '{ -1000,      0,   1000,      0, 32768},
      '{  5000,  -3000,   2000,   7000, 49152},
      '{ 32767,  32767,  32767,  32767, 65535},
      '{-32768, -32768, -32768, -32768, 12345},
      '{     1,      4,      9,     16, 32768},
      '{ 12000, -12000,  12000, -12000,  8192},
      '{-20000,  -5000,  10000,  25000, 60000},
      '{     7,     -7,    300,   -300,     1}
   };

   function automatic int model(int a, int b, int c, int d, int f);
      real t, p, lm, l0, l1, l2;
      t  = real'(f) / 65536.0;
      lm = -t * (t - 1.0) * (t - 2.0) / 6.0;
      l0 = (t + 1.0) * (t - 1.0) * (t - 2.0) / 2.0;
      l1 = -(t + 1.0) * t * (t - 2.0) / 2.0;
      l2 = (t + 1.0) * t * (t - 1.0) / 6.0;
      p  = $floor(a * lm + b * l0 + c * l1 + d * l2 + 0.5);
      if (p > 32767.0)  return 32767;
      if (p < -32768.0) return -32768;
      return int'(p);
   endfunction

   task automatic check(input string tag, input int act, input int exp, input int tol);
      int diff;
      n_checks++;
      diff = act - exp;
      if (diff < 0) diff = -diff;
      if (diff > tol) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at a falling edge
   task automatic push(input int s);
      in_valid  = 1'b1;
      in_sample = 16'(s);
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   // Request, wait for the fourth edge counting the accepting one, sample
   task automatic request(input int f);
      req_valid = 1'b1;
      req_frac  = 16'(f);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         finish_run();
      end
   end

   initial begin
      int e;
      repeat (3) @(negedge clk);
      // R1: idle in reset
      check("R1 out_valid in reset", int'(out_valid), 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0, 0);

      // R2: request with only three samples loaded is dropped
      push(10); push(20); push(30);
      request(0);
      check("R2 no output before window full", int'(out_valid), 0, 0);
      repeat (3) @(negedge clk);
      check("R2 no late output", int'(out_valid), 0, 0);

      // Vector table: R6 general cubic, R4 latency each time
      for (int i = 0; i < NV; i++) begin
         for (int k = 0; k < 4; k++) push(VEC[i][k]);
         request(VEC[i][4]);
         check("R4 out_valid at latency", int'(out_valid), 1, 0);
         e = model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
         check("R6 table vector", int'($signed(out_sample)), e, 1);
         @(negedge clk);
         check("R4 single pulse", int'(out_valid), 0, 0);
      end

      // R5: zero fraction gives position-0 sample exactly
      push(-123); push(4567); push(-32768); push(32767);
      request(0);
      check("R5 t=0 exact", int'($signed(out_sample)), 4567, 0);

      // R3: one more sample moves the window by one
      push(-999);
      request(0);
      check("R3 window shift", int'($signed(out_sample)), -32768, 0);

      // R7: saturation both ways
      push(-32768); push(32767); push(32767); push(-32768);
      request(32768);
      check("R7 positive saturation", int'($signed(out_sample)), 32767, 0);
      push(32767); push(-32768); push(-32768); push(32767);
      request(32768);
      check("R7 negative saturation", int'($signed(out_sample)), -32768, 0);

      // R4: back-to-back requests
      push(0); push(1000); push(3000); push(-2000);
      req_valid = 1'b1; req_frac = 16'd16384;
      @(negedge clk);
      req_frac = 16'd49152;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R4 first of pair valid", int'(out_valid), 1, 0);
      check("R4 first of pair value", int'($signed(out_sample)),
            model(0, 1000, 3000, -2000, 16384), 1);
      @(negedge clk);
      check("R4 second of pair valid", int'(out_valid), 1, 0);
      check("R4 second of pair value", int'($signed(out_sample)),
            model(0, 1000, 3000, -2000, 49152), 1);

      // R8: request alongside a new sample uses the old window
      push(11); push(22); push(33); push(44);
      in_valid = 1'b1; in_sample = 16'd55;
      req_valid = 1'b1; req_frac = 16'd0;
      @(negedge clk);
      in_valid = 1'b0; req_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 same-cycle request uses old window", int'($signed(out_sample)), 22, 0);
      request(0);
      check("R8 next request sees new window", int'($signed(out_sample)), 33, 0);

      finish_run();
   end
endmodule